// File: doc/BRIEF.md
# Dual-View Shared Bit Memory

This block is a 4096-bit memory reached through two fully independent ports. Each port has its own clock, reset, enable, write enable, shape code, address, write data and read data. On every access a port picks how it views the storage. The views run from 4096 one-bit locations down to 256 sixteen-bit locations. Both ports see the same physical bits, so data written through one view can be read back through any other view.

Every input is captured on the rising edge of the port's own clock. A read therefore needs a clock edge before the output changes, and the read data stays registered until the next enabled edge. There is no stream handshake at the edges. A port accepts one access on each rising edge where its enable is high, and it never applies back-pressure. No valid/ready pair exists because the block cannot stall.

If both ports write overlapping bits on the same edge, the stored result in those bits is undefined. If one port reads bits that the other port writes on that same edge, the read result is also undefined. Users must avoid both cases.

Top module: `dual_view_ram`

## Requirements
- R1: The storage holds 4096 bits. For a view of width W, array bit b sits at address b/W, data lane b mod W. Bits written through any view read back through every other view at the mapped location.
- R2: The shape code selects the view as follows: 0 gives 4096x1, 1 gives 2048x2, 2 gives 1024x4, 3 gives 512x8 and 4 gives 256x16. Codes 5, 6 and 7 act exactly like code 4.
- R3: Each port's shape is sampled per access, independently of the other port. Both ports may access different views on the same edge.
- R4: On an enabled read edge, the read output takes the stored bits at the addressed location. The new value is visible after that edge and not before.
- R5: On an edge with enable and write enable high, the low W bits of the write data are stored at the addressed location. All other array bits are left unchanged.
- R6: On a write edge, the port's read output shows the newly written W bits (write-first).
- R7: While enable is low, nothing is written, even with write enable high, and the read output holds its value.
- R8: Read output bits at positions W and above are always 0.
- R9: Address bits beyond the depth of the selected view are ignored. The address is taken modulo 4096/W.
- R10: While a port's reset is low, that port's read output is 0. Reset does not alter the stored bits.
- R11: On the same edge, the two ports may write disjoint bits that lie in the same 16-bit word, and both writes take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable |
| a_shape | input | 3 | Port A view code |
| a_addr | input | 12 | Port A address |
| a_wdata | input | 16 | Port A write data, low W bits used |
| a_rdata | output | 16 | Port A registered read data |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable |
| b_shape | input | 3 | Port B view code |
| b_addr | input | 12 | Port B address |
| b_wdata | input | 16 | Port B write data, low W bits used |
| b_rdata | output | 16 | Port B registered read data |

## Verification
Every result of an access is due one rising edge after the access is presented. This covers read data, write-first data, the held output and the cleared upper bits. The bench sets inputs on a falling edge and lets exactly one rising edge pass. It then reads the outputs on the next falling edge. A stored bit becomes visible through another view on the access after the writing edge. So each cross-view check issues its read on the cycle after the write and samples it one edge later.

// File: rtl/dvr_pkg.sv
package dvr_pkg;
  // Clamp a view code to the widest supported shape and return log2 of its width.
  function automatic int unsigned shape_log2(input int unsigned code, input int unsigned max_log2);
    return (code > max_log2) ? max_log2 : code;
  endfunction
endpackage

// File: rtl/dvr_view_map.sv
module dvr_view_map #(
  parameter int MEM_BITS = 4096,
  parameter int MAX_W    = 16,
  localparam int ADDR_W    = $clog2(MEM_BITS),
  localparam int LANE_BITS = $clog2(MAX_W),
  localparam int WORD_AW   = ADDR_W - LANE_BITS,
  localparam int SHAPE_W   = $clog2(LANE_BITS + 1)
) (
  input  logic [SHAPE_W-1:0]   shape,
  input  logic [ADDR_W-1:0]    addr,
  output logic [WORD_AW-1:0]   word_idx,
  output logic [LANE_BITS-1:0] lane_off,
  output logic [MAX_W-1:0]     width_mask,
  output logic [MAX_W-1:0]     lane_mask
);
  logic [ADDR_W-1:0] bit_base;
  int unsigned       lw;

  always_comb begin
    lw       = dvr_pkg::shape_log2(32'(shape), LANE_BITS);
    bit_base = addr << lw;
    for (int i = 0; i < MAX_W; i++) begin
      width_mask[i] = (i < (1 << lw));
    end
    word_idx  = bit_base[ADDR_W-1:LANE_BITS];
    lane_off  = bit_base[LANE_BITS-1:0];
    lane_mask = width_mask << lane_off;
  end
endmodule

// File: rtl/dvr_bank.sv
module dvr_bank #(
  parameter int WORDS = 256,
  parameter int MAX_W = 16,
  localparam int WORD_AW = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [WORD_AW-1:0] widx,
  input  logic [MAX_W-1:0]   wmask,
  input  logic [MAX_W-1:0]   wbits,
  input  logic [WORD_AW-1:0] ridx_own,
  input  logic [WORD_AW-1:0] ridx_rem,
  output logic [MAX_W-1:0]   rd_own,
  output logic [MAX_W-1:0]   rd_rem
);
  logic [MAX_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[widx] <= (mem[widx] & ~wmask) | (wbits & wmask);
    end
  end

  assign rd_own = mem[ridx_own];
  assign rd_rem = mem[ridx_rem];
endmodule

// File: rtl/dvr_port.sv
module dvr_port #(
  parameter int MAX_W = 16,
  localparam int LANE_BITS = $clog2(MAX_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 we,
  input  logic [LANE_BITS-1:0] lane_off,
  input  logic [MAX_W-1:0]     width_mask,
  input  logic [MAX_W-1:0]     wdata,
  input  logic [MAX_W-1:0]     own_word,
  input  logic [MAX_W-1:0]     other_word,
  output logic                 bank_we,
  output logic [MAX_W-1:0]     bank_bits,
  output logic [MAX_W-1:0]     rdata
);
  logic [MAX_W-1:0] wkeep;
  logic [MAX_W-1:0] live_word;
  logic [MAX_W-1:0] rd_next;

  always_comb begin
    wkeep     = wdata & width_mask;
    live_word = own_word ^ other_word;
    bank_we   = en & we;
    bank_bits = (wkeep << lane_off) ^ other_word;
    rd_next   = we ? wkeep : ((live_word >> lane_off) & width_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (en) begin
      rdata <= rd_next;
    end
  end
endmodule

// File: rtl/dual_view_ram.sv
module dual_view_ram #(
  parameter int MEM_BITS = 4096,
  parameter int MAX_W    = 16,
  localparam int ADDR_W    = $clog2(MEM_BITS),
  localparam int LANE_BITS = $clog2(MAX_W),
  localparam int WORDS     = MEM_BITS / MAX_W,
  localparam int WORD_AW   = ADDR_W - LANE_BITS,
  localparam int SHAPE_W   = $clog2(LANE_BITS + 1)
) (
  input  logic               a_clk,
  input  logic               a_rst_n,
  input  logic               a_en,
  input  logic               a_we,
  input  logic [SHAPE_W-1:0] a_shape,
  input  logic [ADDR_W-1:0]  a_addr,
  input  logic [MAX_W-1:0]   a_wdata,
  output logic [MAX_W-1:0]   a_rdata,
  input  logic               b_clk,
  input  logic               b_rst_n,
  input  logic               b_en,
  input  logic               b_we,
  input  logic [SHAPE_W-1:0] b_shape,
  input  logic [ADDR_W-1:0]  b_addr,
  input  logic [MAX_W-1:0]   b_wdata,
  output logic [MAX_W-1:0]   b_rdata
);
  logic               clk_v   [2];
  logic               rst_v   [2];
  logic               en_v    [2];
  logic               we_v    [2];
  logic [SHAPE_W-1:0] shape_v [2];
  logic [ADDR_W-1:0]  addr_v  [2];
  logic [MAX_W-1:0]   wdata_v [2];
  logic [MAX_W-1:0]   rdata_v [2];

  logic [WORD_AW-1:0]   widx     [2];
  logic [LANE_BITS-1:0] loff     [2];
  logic [MAX_W-1:0]     wmask_lo [2];
  logic [MAX_W-1:0]     lmask    [2];
  logic [MAX_W-1:0]     own_rd   [2];
  logic [MAX_W-1:0]     rem_rd   [2];
  logic                 bwe      [2];
  logic [MAX_W-1:0]     bbits    [2];

  assign clk_v   = '{a_clk, b_clk};
  assign rst_v   = '{a_rst_n, b_rst_n};
  assign en_v    = '{a_en, b_en};
  assign we_v    = '{a_we, b_we};
  assign shape_v = '{a_shape, b_shape};
  assign addr_v  = '{a_addr, b_addr};
  assign wdata_v = '{a_wdata, b_wdata};
  assign a_rdata = rdata_v[0];
  assign b_rdata = rdata_v[1];

  // One bank per port; the live value of a word is the XOR of both banks.
  for (genvar p = 0; p < 2; p++) begin : g_side
    localparam int Q = 1 - p;

    dvr_view_map #(.MEM_BITS(MEM_BITS), .MAX_W(MAX_W)) u_map (
      .shape(shape_v[p]), .addr(addr_v[p]),
      .word_idx(widx[p]), .lane_off(loff[p]),
      .width_mask(wmask_lo[p]), .lane_mask(lmask[p])
    );

    dvr_bank #(.WORDS(WORDS), .MAX_W(MAX_W)) u_bank (
      .clk(clk_v[p]), .we(bwe[p]), .widx(widx[p]),
      .wmask(lmask[p]), .wbits(bbits[p]),
      .ridx_own(widx[p]), .ridx_rem(widx[Q]),
      .rd_own(own_rd[p]), .rd_rem(rem_rd[p])
    );

    dvr_port #(.MAX_W(MAX_W)) u_port (
      .clk(clk_v[p]), .rst_n(rst_v[p]), .en(en_v[p]), .we(we_v[p]),
      .lane_off(loff[p]), .width_mask(wmask_lo[p]), .wdata(wdata_v[p]),
      .own_word(own_rd[p]), .other_word(rem_rd[Q]),
      .bank_we(bwe[p]), .bank_bits(bbits[p]), .rdata(rdata_v[p])
    );
  end
endmodule

// File: rtl/dvr_chk.sv
module dvr_chk #(
  parameter int MAX_W   = 16,
  parameter int SHAPE_W = 3
) (
  input logic               a_clk,
  input logic               a_rst_n,
  input logic               a_en,
  input logic               a_we,
  input logic [SHAPE_W-1:0] a_shape,
  input logic [MAX_W-1:0]   a_wdata,
  input logic [MAX_W-1:0]   a_rdata,
  input logic               b_clk,
  input logic               b_rst_n,
  input logic               b_en,
  input logic               b_we,
  input logic [SHAPE_W-1:0] b_shape,
  input logic [MAX_W-1:0]   b_wdata,
  input logic [MAX_W-1:0]   b_rdata
);
  localparam int LANE_BITS = $clog2(MAX_W);

  function automatic logic [MAX_W-1:0] lo_mask(input logic [SHAPE_W-1:0] s);
    logic [MAX_W-1:0] m;
    int unsigned lw;
    lw = dvr_pkg::shape_log2(32'(s), LANE_BITS);
    for (int i = 0; i < MAX_W; i++) m[i] = (i < (1 << lw));
    return m;
  endfunction

  // R7
  a_hold_chk: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    !a_en |=> $stable(a_rdata));
  // R7
  b_hold_chk: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    !b_en |=> $stable(b_rdata));
  // R6
  a_wfirst_chk: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    (a_en && a_we) |=> a_rdata == ($past(a_wdata) & lo_mask($past(a_shape))));
  // R6
  b_wfirst_chk: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    (b_en && b_we) |=> b_rdata == ($past(b_wdata) & lo_mask($past(b_shape))));
  // R8
  a_upper_chk: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    a_en |=> (a_rdata & ~lo_mask($past(a_shape))) == '0);
  // R8
  b_upper_chk: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    b_en |=> (b_rdata & ~lo_mask($past(b_shape))) == '0);
  // R10
  a_rst_chk: assert property (@(posedge a_clk) !a_rst_n |-> a_rdata == '0);
  // R10
  b_rst_chk: assert property (@(posedge b_clk) !b_rst_n |-> b_rdata == '0);
endmodule

bind dual_view_ram dvr_chk #(.MAX_W(MAX_W), .SHAPE_W(SHAPE_W)) u_chk (
  .a_clk(a_clk), .a_rst_n(a_rst_n), .a_en(a_en), .a_we(a_we),
  .a_shape(a_shape), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .b_clk(b_clk), .b_rst_n(b_rst_n), .b_en(b_en), .b_we(b_we),
  .b_shape(b_shape), .b_wdata(b_wdata), .b_rdata(b_rdata)
);

// File: tb/dual_view_ram_bench.sv
`timescale 1ns/1ps
module dual_view_ram_bench;
  logic        clk = 1'b0;
  logic        a_rst_n = 1'b0, b_rst_n = 1'b0;
  logic        a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
  logic [2:0]  a_shape = '0, b_shape = '0;
  logic [11:0] a_addr = '0, b_addr = '0;
  logic [15:0] a_wdata = '0, b_wdata = '0;
  logic [15:0] a_rdata, b_rdata;

  int total = 0;
  int bad   = 0;
  bit refm [4096];

  always #5 clk = ~clk;

  dual_view_ram u_dual_view_ram (
    .a_clk(clk), .a_rst_n(a_rst_n), .a_en(a_en), .a_we(a_we), .a_shape(a_shape),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_clk(clk), .b_rst_n(b_rst_n), .b_en(b_en), .b_we(b_we), .b_shape(b_shape),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  function automatic int wlog(input int s);
    return (s > 4) ? 4 : s;
  endfunction

  function automatic logic [15:0] exp_rd(input int s, input int addr);
    int w = 1 << wlog(s);
    int base = ((addr % (4096 / w)) * w);
    logic [15:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = refm[base + i];
    return r;
  endfunction

  function automatic logic [15:0] lowbits(input int s, input logic [15:0] d);
    logic [15:0] r = '0;
    for (int i = 0; i < (1 << wlog(s)); i++) r[i] = d[i];
    return r;
  endfunction

  task automatic ref_wr(input int s, input int addr, input logic [15:0] d);
    int w = 1 << wlog(s);
    int base = ((addr % (4096 / w)) * w);
    for (int i = 0; i < w; i++) refm[base + i] = d[i];
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_a(input bit en, input bit we, input int s, input int addr, input logic [15:0] d);
    a_en = en; a_we = we; a_shape = 3'(s); a_addr = 12'(addr); a_wdata = d;
  endtask

  task automatic set_b(input bit en, input bit we, input int s, input int addr, input logic [15:0] d);
    b_en = en; b_we = we; b_shape = 3'(s); b_addr = 12'(addr); b_wdata = d;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    set_a(0, 0, 0, 0, '0);
    set_b(0, 0, 0, 0, '0);
  endtask

  // R10: outputs cleared during reset
  task automatic t_reset();
    repeat (3) tick();
    check("R10 reset a_rdata", a_rdata, 16'h0000);
    check("R10 reset b_rdata", b_rdata, 16'h0000);
    a_rst_n = 1'b1; b_rst_n = 1'b1;
    tick();
  endtask

  // R6, R5: fill the whole array through the 16-bit view of port B
  task automatic t_fill();
    for (int i = 0; i < 256; i++) begin
      logic [15:0] d = 16'((i * 16'h9E37) ^ 16'hC3A5);
      set_b(1, 1, 4, i, d);
      tick();
      check("R6 fill write-first", b_rdata, d);
      ref_wr(4, i, d);
    end
    idle();
  endtask

  // R1, R2, R3, R4: read every view on A while B reads a different view
  task automatic t_views();
    for (int s = 0; s < 5; s++) begin
      int dep = 4096 >> s;
      int dpb = 4096 >> (4 - s);
      int list [5] = '{0, 1, 3, dep / 2 + 7, dep - 1};
      for (int k = 0; k < 5; k++) begin
        int ab = (list[k] * 7 + 5) % dpb;
        set_a(1, 0, s, list[k], 16'hFFFF);
        set_b(1, 0, 4 - s, ab, 16'hFFFF);
        tick();
        check("R1 R2 R4 view read a", a_rdata, exp_rd(s, list[k]));
        check("R3 other-view read b", b_rdata, exp_rd(4 - s, ab));
      end
    end
    idle();
  endtask

  // R5, R1: narrow writes seen through wider views
  task automatic t_narrow();
    logic [15:0] d = {15'b0, ~refm[4095]};
    set_a(1, 1, 0, 4095, d);
    tick();
    ref_wr(0, 4095, d);
    idle(); set_b(1, 0, 4, 255, '0);
    tick();
    check("R5 R1 bit write seen in word", b_rdata, exp_rd(4, 255));
    set_a(1, 1, 2, 513, 16'hFFF6);
    tick();
    ref_wr(2, 513, 16'h0006);
    idle(); set_b(1, 0, 1, 1026, '0);
    tick();
    check("R5 nibble low pair", b_rdata, exp_rd(1, 1026));
    set_b(1, 0, 1, 1027, '0);
    tick();
    check("R5 nibble high pair", b_rdata, exp_rd(1, 1027));
    set_b(1, 0, 4, 128, '0);
    tick();
    check("R5 neighbours unchanged", b_rdata, exp_rd(4, 128));
    idle();
  endtask

  // R2: codes 5..7 behave like code 4
  task automatic t_bad_shape();
    for (int s = 5; s < 8; s++) begin
      set_a(1, 0, s, 37, '0);
      tick();
      check("R2 wide alias code", a_rdata, exp_rd(4, 37));
    end
    idle();
  endtask

  // R9: upper address bits dropped
  task automatic t_wrap();
    set_a(1, 0, 3, 512 + 9, '0);
    tick();
    check("R9 wrap 512x8", a_rdata, exp_rd(3, 9));
    set_a(1, 0, 4, 3 * 256 + 200, '0);
    tick();
    check("R9 wrap 256x16", a_rdata, exp_rd(4, 200));
    idle();
  endtask

  // R8: bits above the view width read as zero
  task automatic t_upper();
    set_a(1, 1, 1, 5, 16'hFFFF);
    tick();
    check("R8 write-first 2-bit", a_rdata, 16'h0003);
    ref_wr(1, 5, 16'h0003);
    set_a(1, 0, 3, 1, '0);
    tick();
    check("R8 byte read upper zero", a_rdata, exp_rd(3, 1));
    idle();
  endtask

  // R7: disabled port neither writes nor changes its output
  task automatic t_hold();
    logic [15:0] v;
    set_a(1, 0, 4, 10, '0);
    tick();
    v = exp_rd(4, 10);
    check("R7 setup read", a_rdata, v);
    set_a(0, 1, 4, 10, ~v);
    tick();
    check("R7 output held", a_rdata, v);
    set_a(0, 0, 0, 77, 16'h1234);
    tick();
    check("R7 output held idle", a_rdata, v);
    set_a(1, 0, 4, 10, '0);
    tick();
    check("R7 no write while disabled", a_rdata, v);
    idle();
  endtask

  // R11, R3: both ports write disjoint halves of one word on the same edge
  task automatic t_dual();
    set_a(1, 1, 3, 40, 16'h00A7);
    set_b(1, 1, 3, 41, 16'h003C);
    tick();
    check("R11 a write-first", a_rdata, 16'h00A7);
    check("R11 b write-first", b_rdata, 16'h003C);
    ref_wr(3, 40, 16'h00A7);
    ref_wr(3, 41, 16'h003C);
    idle(); set_b(1, 0, 4, 20, '0); set_a(1, 0, 0, 320 + 9, '0);
    tick();
    check("R11 merged word", b_rdata, 16'h3CA7);
    check("R11 single bit", a_rdata, exp_rd(0, 329));
    idle();
  endtask

  // R10: reset keeps storage
  task automatic t_reset_keep();
    a_rst_n = 1'b0; b_rst_n = 1'b0;
    tick(); tick();
    check("R10 mid reset a", a_rdata, 16'h0000);
    check("R10 mid reset b", b_rdata, 16'h0000);
    a_rst_n = 1'b1; b_rst_n = 1'b1;
    tick();
    set_a(1, 0, 4, 20, '0);
    tick();
    check("R10 storage kept", a_rdata, 16'h3CA7);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    t_views();
    t_narrow();
    t_bad_shape();
    t_wrap();
    t_upper();
    t_hold();
    t_dual();
    t_reset_keep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule